// File: doc/BRIEF.md
# Loss of Signal and Loss of Clock Supervisor

This block watches a recovered line stream and reports two active-low alarms: loss of signal and loss of clock. Loss of signal merges an external analog "no signal" flag with a digital detector that counts consecutive zero bits. When the local loopback is selected, only the digital detector is used. Loss of clock is raised in two cases: when shutdown is enabled while the signal is lost, and when the recovered clock stops toggling.

The block runs on the reference clock. The recovered clock and data pass through a two-stage synchroniser. Each synchronised rising edge of the recovered clock samples one bit and resets a gap counter. When shutdown is enabled during loss of signal, the block also silences the receive-side outputs. An active-low alarm-test input drives both alarms low and leaves the receive data path untouched.

Top module: `los_loc_supervisor`

## Requirements
- R1: The digital detector becomes active on the 129th consecutive zero bit, that is, once more than ZERO_LIMIT (128) zeros have arrived. A run of exactly 128 zeros does not activate it. Any one bit clears the run. The run counter saturates and never wraps.
- R2: Outside loopback, `los_n_o` is 0 when `ana_los_i` is 1 or the digital detector is active, and 1 otherwise.
- R3: With `loop_local_n_i` = 0, `ana_los_i` has no effect, and `los_n_o` follows only the digital detector.
- R4: With `shutdown_i` = 1 and loss of signal active, `loc_n_o` is 0. With `shutdown_i` = 0 and recovered clock edges arriving every 2 reference cycles, `loc_n_o` stays 1 during loss of signal.
- R5: In single-rail mode (`dual_rail_i` = 0), shutdown with loss of signal drives `rx_clk_o` = 1 and `rx_p_o` = 1, while `rx_n_o` follows `rx_neg_i`. Without that squelch, `rx_clk_o`, `rx_p_o` and `rx_n_o` follow `rec_clk_i`, `rx_pos_i` and `rx_neg_i`.
- R6: In dual-rail mode (`dual_rail_i` = 1), shutdown with loss of signal drives `rx_p_o` = 0, `rx_n_o` = 0 and `rx_clk_o` = 1.
- R7: `loc_n_o` goes to 0 once GAP_LIMIT (4) consecutive reference cycles pass with no synchronised rising edge of `rec_clk_i`. Edges spaced 4 cycles apart never trigger it, edges spaced 5 cycles apart do, and the next edge clears it.
- R8: With `alarm_test_n_i` = 0, `los_n_o` and `loc_n_o` are both 0, and the receive outputs behave as if alarm test were inactive.
- R9: While `rst_n` is 0, `los_n_o` = 1 and `loc_n_o` = 1 when `ana_los_i` = 0 and `alarm_test_n_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_clk_i | input | 1 | Recovered line clock (asynchronous) |
| rec_data_i | input | 1 | Recovered bit, 1 = mark, sampled on recovered clock rise |
| ana_los_i | input | 1 | Analog detector reports no signal (active-high) |
| loop_local_n_i | input | 1 | Local loopback select, active-low |
| shutdown_i | input | 1 | Enables squelch and loss-of-clock on loss of signal |
| alarm_test_n_i | input | 1 | Alarm test, active-low |
| dual_rail_i | input | 1 | 0 = single-rail, 1 = dual-rail receive outputs |
| rx_pos_i | input | 1 | Receive data (single-rail active-low) or positive rail |
| rx_neg_i | input | 1 | Violation flag (single-rail) or negative rail |
| los_n_o | output | 1 | Loss of signal, active-low |
| loc_n_o | output | 1 | Loss of clock, active-low |
| rx_clk_o | output | 1 | Gated receive clock |
| rx_p_o | output | 1 | Gated receive data or positive rail |
| rx_n_o | output | 1 | Gated violation flag or negative rail |

## Verification
The bench sends zero runs of exactly 128 and 129 bits, plus random runs close to that limit. A detector that is off by one, or one whose counter wraps, would report the wrong loss-of-signal state. Edge spacings of 4 and 5 reference cycles bracket the gap limit, so a monitor with the wrong limit either never flags loss of clock or flags it on a healthy clock. Random mixes of loopback, analog flag, shutdown, rail mode and alarm test expose three faults: an analog flag leaking into loopback, squelch polarity swapped between the rail modes, and alarm test disturbing the data outputs.

// File: rtl/lsv_pkg.sv
package lsv_pkg;
    typedef enum logic {
        RAIL_SINGLE = 1'b0,
        RAIL_DUAL   = 1'b1
    } rail_mode_e;

    typedef struct packed {
        logic sig_lost;
        logic clk_lost;
        logic squelch;
    } alarm_vec_t;
endpackage

// File: rtl/lsv_edge_sync.sv
module lsv_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_clk_i,
    input  logic async_dat_i,
    output logic edge_o,
    output logic bit_o
);
    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [TOP:0] clk_sh;
        logic [TOP:0] dat_sh;
        logic         prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (STAGES > 1) begin
            s_d.clk_sh = {s_q.clk_sh[TOP-1:0], async_clk_i};
            s_d.dat_sh = {s_q.dat_sh[TOP-1:0], async_dat_i};
        end else begin
            s_d.clk_sh = async_clk_i;
            s_d.dat_sh = async_dat_i;
        end
        s_d.prev = s_q.clk_sh[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign edge_o = s_q.clk_sh[TOP] & ~s_q.prev;
    assign bit_o  = s_q.dat_sh[TOP];

    // R7: two edges are never flagged on consecutive cycles
    a_r7_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/lsv_zero_run.sv
module lsv_zero_run #(
    parameter int ZERO_LIMIT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld_i,
    input  logic bit_i,
    output logic dig_los_o
);
    localparam int SAT   = ZERO_LIMIT + 1;
    localparam int CNT_W = $clog2(SAT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] run;
    } zr_t;

    zr_t z_d, z_q;

    always_comb begin
        z_d = z_q;
        if (bit_vld_i) begin
            if (bit_i)
                z_d.run = '0;
            else if (z_q.run != CNT_W'(SAT))
                z_d.run = z_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) z_q <= '0;
        else        z_q <= z_d;
    end

    assign dig_los_o = (z_q.run == CNT_W'(SAT));

    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        z_q.run <= CNT_W'(SAT));
    a_r1_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld_i && bit_i) |=> !dig_los_o);
    a_r1_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dig_los_o) |-> $past(bit_vld_i && !bit_i));
endmodule

// File: rtl/lsv_gap_mon.sv
module lsv_gap_mon #(
    parameter int GAP_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic absent_o
);
    localparam int GAP_W = $clog2(GAP_LIMIT + 1);

    typedef struct packed {
        logic [GAP_W-1:0] gap;
    } gm_t;

    gm_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (edge_i)
            g_d.gap = '0;
        else if (g_q.gap != GAP_W'(GAP_LIMIT))
            g_d.gap = g_q.gap + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign absent_o = (g_q.gap == GAP_W'(GAP_LIMIT));

    a_r7_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> !absent_o);
    a_r7_rise_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(absent_o) |-> $past(!edge_i));
endmodule

// File: rtl/lsv_out_gate.sv
module lsv_out_gate
    import lsv_pkg::*;
(
    input  logic squelch_i,
    input  logic dual_rail_i,
    input  logic rec_clk_i,
    input  logic rx_pos_i,
    input  logic rx_neg_i,
    output logic rx_clk_o,
    output logic rx_p_o,
    output logic rx_n_o
);
    rail_mode_e mode;

    always_comb begin
        mode     = rail_mode_e'(dual_rail_i);
        rx_clk_o = rec_clk_i;
        rx_p_o   = rx_pos_i;
        rx_n_o   = rx_neg_i;
        if (squelch_i) begin
            rx_clk_o = 1'b1;
            if (mode == RAIL_DUAL) begin
                rx_p_o = 1'b0;
                rx_n_o = 1'b0;
            end else begin
                rx_p_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/los_loc_supervisor.sv
module los_loc_supervisor
    import lsv_pkg::*;
#(
    parameter int ZERO_LIMIT  = 128,
    parameter int GAP_LIMIT   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rec_clk_i,
    input  logic rec_data_i,
    input  logic ana_los_i,
    input  logic loop_local_n_i,
    input  logic shutdown_i,
    input  logic alarm_test_n_i,
    input  logic dual_rail_i,
    input  logic rx_pos_i,
    input  logic rx_neg_i,
    output logic los_n_o,
    output logic loc_n_o,
    output logic rx_clk_o,
    output logic rx_p_o,
    output logic rx_n_o
);
    logic       bit_edge, bit_val, dig_los, clk_absent;
    alarm_vec_t alm;

    lsv_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_clk_i(rec_clk_i), .async_dat_i(rec_data_i),
        .edge_o(bit_edge), .bit_o(bit_val)
    );

    lsv_zero_run #(.ZERO_LIMIT(ZERO_LIMIT)) u_zero (
        .clk(clk), .rst_n(rst_n),
        .bit_vld_i(bit_edge), .bit_i(bit_val),
        .dig_los_o(dig_los)
    );

    lsv_gap_mon #(.GAP_LIMIT(GAP_LIMIT)) u_gap (
        .clk(clk), .rst_n(rst_n),
        .edge_i(bit_edge), .absent_o(clk_absent)
    );

    always_comb begin
        alm.sig_lost = (ana_los_i & loop_local_n_i) | dig_los;
        alm.squelch  = shutdown_i & alm.sig_lost;
        alm.clk_lost = alm.squelch | clk_absent;
        los_n_o      = ~(alm.sig_lost | ~alarm_test_n_i);
        loc_n_o      = ~(alm.clk_lost | ~alarm_test_n_i);
    end

    lsv_out_gate u_gate (
        .squelch_i(alm.squelch), .dual_rail_i(dual_rail_i),
        .rec_clk_i(rec_clk_i), .rx_pos_i(rx_pos_i), .rx_neg_i(rx_neg_i),
        .rx_clk_o(rx_clk_o), .rx_p_o(rx_p_o), .rx_n_o(rx_n_o)
    );

    a_r8_alarm_forces: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_test_n_i |-> (!los_n_o && !loc_n_o));
    a_r4_sd_loc: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_i && !los_n_o) |-> !loc_n_o);
    a_r3_loop_ignores_analog: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_local_n_i && !dig_los && alarm_test_n_i) |-> los_n_o);
    a_r6_dual_squelch: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_rail_i && shutdown_i && dig_los) |-> (!rx_p_o && !rx_n_o && rx_clk_o));
    a_r5_single_squelch: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_rail_i && shutdown_i && dig_los) |-> (rx_p_o && rx_clk_o));
endmodule

// File: tb/los_loc_supervisor_tb_top.sv
`timescale 1ns/1ps
module los_loc_supervisor_tb_top;
    localparam real HALF = 2.5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rec_clk = 0, rec_data = 0, ana = 0, loop_n = 1, sd = 0, alarm_n = 1;
    logic dual = 0, rxp = 0, rxn = 0;
    logic los_n, loc_n, rxc_o, rxp_o, rxn_o;

    int nchk = 0, nfail = 0, zrun = 0, lowseen = 0;
    bit watch_en = 0;
    logic w_los_n, w_loc_n;
    string w_tag;
    bit finished = 0;

    always #(HALF) clk = ~clk;

    los_loc_supervisor dut_i (
        .clk(clk), .rst_n(rst_n), .rec_clk_i(rec_clk), .rec_data_i(rec_data),
        .ana_los_i(ana), .loop_local_n_i(loop_n), .shutdown_i(sd),
        .alarm_test_n_i(alarm_n), .dual_rail_i(dual), .rx_pos_i(rxp), .rx_neg_i(rxn),
        .los_n_o(los_n), .loc_n_o(loc_n), .rx_clk_o(rxc_o), .rx_p_o(rxp_o), .rx_n_o(rxn_o)
    );

    function automatic logic exp_lost();
        return (ana & loop_n) | (zrun > 128);
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    // one recovered bit: clock high for hi cycles, low for lo cycles
    task automatic send_bit(input logic b, input int hi, input int lo);
        for (int c = 0; c < hi + lo; c++) begin
            @(negedge clk);
            if (c == 0) begin rec_data = b; rec_clk = 1'b1; end
            else if (c == hi) rec_clk = 1'b0;
            @(posedge clk); #1;
            if (loc_n === 1'b0) lowseen++;
            if (watch_en) begin
                chk({w_tag, " los_n"}, los_n, w_los_n);
                chk({w_tag, " loc_n"}, loc_n, w_loc_n);
            end
        end
        if (b) zrun = 0; else if (zrun < 129) zrun++;
    endtask

    // stop clock, let everything settle, compare all outputs
    task automatic stop_check(input string tag);
        logic lost, sq;
        rec_clk = 1'b0;
        repeat (12) @(negedge clk);
        lost = exp_lost();
        sq   = sd & lost;
        chk({tag, " los_n"}, los_n, ~(lost | ~alarm_n));
        chk({tag, " loc_n (R7 stopped)"}, loc_n, 1'b0);
        chk({tag, " rx_clk"}, rxc_o, sq ? 1'b1 : 1'b0);
        chk({tag, " rx_p"}, rxp_o, sq ? ~dual : rxp);
        chk({tag, " rx_n"}, rxn_o, (sq & dual) ? 1'b0 : rxn);
    endtask

    initial begin
        #(HALF * 2 * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        repeat (5) @(negedge clk);
        // R9 reset state
        chk("R9 reset los_n", los_n, 1'b1);
        chk("R9 reset loc_n", loc_n, 1'b1);
        rst_n = 1'b1;

        // R1 boundary: 128 zeros no alarm, 129th sets it, one clears
        send_bit(1'b1, 1, 1);
        repeat (128) send_bit(1'b0, 1, 1);
        stop_check("R1 run of 128");
        send_bit(1'b0, 1, 1);
        stop_check("R1 run of 129");
        repeat (300) send_bit(1'b0, 1, 1);
        stop_check("R1 saturated run");
        send_bit(1'b1, 1, 1);
        stop_check("R1 one clears");

        // R2 analog flag with running clock, no shutdown: R4 LOC stays high
        ana = 1'b1;
        repeat (6) send_bit(1'b1, 1, 1);
        w_tag = "R4 no shutdown"; w_los_n = 1'b0; w_loc_n = 1'b1; watch_en = 1;
        repeat (20) send_bit(1'b1, 1, 1);
        watch_en = 0;
        stop_check("R2 analog loss");
        // R4 shutdown forces LOC while running; R5 squelch
        sd = 1'b1;
        repeat (6) send_bit(1'b1, 1, 1);
        w_tag = "R4 shutdown"; w_los_n = 1'b0; w_loc_n = 1'b0; watch_en = 1;
        repeat (20) send_bit(1'b1, 1, 1);
        watch_en = 0;
        rxp = 0; rxn = 1; stop_check("R5 single squelch");
        dual = 1; rxp = 1; rxn = 1; stop_check("R6 dual squelch");
        // R3 loopback hides analog flag
        loop_n = 1'b0; stop_check("R3 loopback");
        loop_n = 1'b1; sd = 1'b0; ana = 1'b0; dual = 0;
        // R8 alarm test, receive path untouched
        alarm_n = 1'b0; rxp = 1; rxn = 0; stop_check("R8 alarm test");
        alarm_n = 1'b1;

        // R7 gap limit: spacing 4 never flags, spacing 5 does
        repeat (4) send_bit(1'b1, 2, 2);
        w_tag = "R7 spacing 4"; w_los_n = 1'b1; w_loc_n = 1'b1; watch_en = 1;
        repeat (20) send_bit(1'b1, 2, 2);
        watch_en = 0;
        lowseen = 0;
        repeat (20) send_bit(1'b1, 2, 3);
        chk("R7 spacing 5 flags", lowseen > 0, 1'b1);

        // random mix around the zero limit
        for (int it = 0; it < 40; it++) begin
            int len;
            ana     = 1'($urandom_range(0, 1));
            loop_n  = 1'($urandom_range(0, 1));
            sd      = 1'($urandom_range(0, 1));
            dual    = 1'($urandom_range(0, 1));
            alarm_n = ($urandom_range(0, 7) != 0);
            rxp     = 1'($urandom_range(0, 1));
            rxn     = 1'($urandom_range(0, 1));
            len = (it % 2) ? $urandom_range(126, 131) : $urandom_range(0, 140);
            send_bit(1'b1, 1, 1);
            for (int k = 0; k < len; k++) send_bit(1'b0, 1, 1);
            stop_check((exp_lost() && (zrun > 128)) ? "R1 random run" : "R2 random mix");
        end
        summary();
    end
endmodule